// File: doc/BRIEF.md
# Supply Voltage Emergency Controller

This block watches a digitised core supply sample that arrives every clock cycle. It compares each sample against a window of two programmable control limits and two outer hard limits. When the supply sags below the lower control limit, the block asks the pipeline to throttle resources so that the core draws less current. When the supply rises above the upper control limit, it asks for phantom firing so that the core draws more current. Once engaged, an actuator stays on until the supply has been back inside the control window for a programmable number of consecutive cycles.

Each time the supply leaves the window, the block builds a two-field record: an event kind, and the program counter presented with the offending sample. It writes the record into a small queue that a software layer drains through a valid/ready port. Because the record carries the program counter, software can bin events by code location and then rewrite the few sequences that cause most of them. A saturating counter tracks the total number of excursions. A sticky flag shows that at least one record was lost because the queue was full.

Top module: `vdroop_guard`

## Requirements
- R1: After reset, throttle_o, phantom_o, evt_valid_o, overflow_o and total_cnt_o are all zero. The limits reset to codes 50/70/130/150 and the hold time resets to 8.
- R2: The sample code is millivolts above 900 mV. A code below the lower control limit (default 70) is a low excursion. A code above the upper control limit (default 130) is a high excursion. Codes equal to either limit are inside the window.
- R3: A low-excursion sample raises throttle_o and clears phantom_o from the next cycle on.
- R4: A high-excursion sample raises phantom_o and clears throttle_o from the next cycle on. The two outputs are never both high. A sample that is both low and high, which can happen with crossed limits, counts as low.
- R5: An engaged actuator drops only after H consecutive in-window samples, where H is the hold time (0 behaves as 1). It drops in the cycle after the H-th such sample. Any sample outside the window restarts the count.
- R6: The record kind is {hard, high}: 00 soft-low, 01 soft-high, 10 hard-low, 11 hard-high. A low excursion is hard when the code is below the lower hard limit (default 50). A high excursion is hard when the code is above the upper hard limit (default 150). evt_pc_o carries pc_i from the sample that started the excursion.
- R7: A record is made only on a sample whose side (low/high) differs from the previous sample's side. Staying outside makes no further records. Jumping straight from low to high, or from high to low, makes a new record.
- R8: Records leave the queue in arrival order. The queue holds 8 entries. A head that is not taken (evt_ready_i low) stays stable.
- R9: A record that arrives while the queue is full is dropped and sets overflow_o, which stays high until reset. If the head is taken in the same cycle, the record is accepted instead.
- R10: total_cnt_o increments on every record, dropped ones included, and saturates at its all-ones value.
- R11: Configuration writes use the cfg_addr_i map 0 lower hard, 1 lower control, 2 upper control, 3 upper hard, 4 hold time (low bits of cfg_wdata_i). Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsample_i | input | 8 | Supply code, mV above 900 mV |
| pc_i | input | 32 | Program counter for the current sample |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 8 | Configuration write data |
| throttle_o | output | 1 | Resource-throttle request |
| phantom_o | output | 1 | Phantom-firing request |
| evt_valid_o | output | 1 | Queue head is valid |
| evt_ready_i | input | 1 | Software takes the head |
| evt_type_o | output | 2 | Head record kind |
| evt_pc_o | output | 32 | Head record program counter |
| total_cnt_o | output | 16 | Saturating excursion count |
| overflow_o | output | 1 | Sticky record-loss flag |

## Verification
The case that decides correctness is a new excursion that arrives in the same cycle as software takes a record from a full queue: a push and a pop at one edge. The bench fills the queue to eight entries with evt_ready_i held low, then raises evt_ready_i in exactly the cycle it presents a fresh excursion. It expects the occupancy to stay at eight, the new record to appear last in the drain order, and overflow_o to stay low. A following excursion with ready low must then set the flag.

// File: rtl/vdg_pkg.sv
package vdg_pkg;
  typedef enum logic [1:0] {
    SIDE_IN = 2'd0,
    SIDE_LO = 2'd1,
    SIDE_HI = 2'd2
  } side_e;

  localparam int unsigned KIND_W = 2;

  function automatic logic [KIND_W-1:0] kind_code(input logic hard, input logic high);
    return {hard, high};
  endfunction
endpackage

// File: rtl/vdg_classify.sv
module vdg_classify
  import vdg_pkg::*;
#(
  parameter int unsigned V_W = 8
) (
  input  logic [V_W-1:0] v_i,
  input  logic [V_W-1:0] hard_lo_i,
  input  logic [V_W-1:0] ctl_lo_i,
  input  logic [V_W-1:0] ctl_hi_i,
  input  logic [V_W-1:0] hard_hi_i,
  output side_e          side_o,
  output logic           hard_o
);
  logic below, above;

  assign below = v_i < ctl_lo_i;
  assign above = v_i > ctl_hi_i;

  // undershoot wins when crossed limits flag both sides
  always_comb begin
    side_o = SIDE_IN;
    hard_o = 1'b0;
    if (below) begin
      side_o = SIDE_LO;
      hard_o = v_i < hard_lo_i;
    end else if (above) begin
      side_o = SIDE_HI;
      hard_o = v_i > hard_hi_i;
    end
  end
endmodule

// File: rtl/vdg_actuator.sv
module vdg_actuator
  import vdg_pkg::*;
#(
  parameter int unsigned HOLD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  side_e             side_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              throttle_o,
  output logic              phantom_o,
  output logic              enter_o
);
  localparam int unsigned CW = HOLD_W + 1;

  side_e             prev_q;
  logic [HOLD_W-1:0] cnt_q;
  logic [CW-1:0]     cnt_nxt;
  logic              done;

  assign enter_o = (side_i != SIDE_IN) && (side_i != prev_q);
  assign cnt_nxt = {1'b0, cnt_q} + CW'(1);
  assign done    = cnt_nxt >= {1'b0, hold_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= SIDE_IN;
      cnt_q      <= '0;
      throttle_o <= 1'b0;
      phantom_o  <= 1'b0;
    end else begin
      prev_q <= side_i;
      unique case (side_i)
        SIDE_LO: begin
          throttle_o <= 1'b1;
          phantom_o  <= 1'b0;
          cnt_q      <= '0;
        end
        SIDE_HI: begin
          throttle_o <= 1'b0;
          phantom_o  <= 1'b1;
          cnt_q      <= '0;
        end
        default: begin
          if (throttle_o || phantom_o) begin
            if (done) begin
              throttle_o <= 1'b0;
              phantom_o  <= 1'b0;
              cnt_q      <= '0;
            end else begin
              cnt_q <= cnt_nxt[HOLD_W-1:0];
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vdg_evt_fifo.sv
module vdg_evt_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 34
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         accept_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          pop, full;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign valid_o  = cnt_q != '0;
  assign full     = cnt_q == CW'(DEPTH);
  assign pop      = valid_o && ready_i;
  assign accept_o = push_i && (!full || pop);
  assign data_o   = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (accept_o && wr_q == AW'(i)) mem_q[i] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (accept_o) wr_q <= bump(wr_q);
      if (pop)      rd_q <= bump(rd_q);
      unique case ({accept_o, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/vdroop_guard.sv
module vdroop_guard
  import vdg_pkg::*;
#(
  parameter int unsigned V_W         = 8,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned HOLD_W      = 4,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned FIFO_DEPTH  = 8,
  parameter int unsigned HARD_LO_RST = 50,
  parameter int unsigned CTL_LO_RST  = 70,
  parameter int unsigned CTL_HI_RST  = 130,
  parameter int unsigned HARD_HI_RST = 150,
  parameter int unsigned HOLD_RST    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [V_W-1:0]    vsample_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [V_W-1:0]    cfg_wdata_i,
  output logic              throttle_o,
  output logic              phantom_o,
  output logic              evt_valid_o,
  input  logic              evt_ready_i,
  output logic [KIND_W-1:0] evt_type_o,
  output logic [PC_W-1:0]   evt_pc_o,
  output logic [CNT_W-1:0]  total_cnt_o,
  output logic              overflow_o
);
  localparam int unsigned REC_W   = KIND_W + PC_W;
  localparam int unsigned N_LIM   = 4;
  localparam logic [2:0]  HOLD_AD = 3'd4;
  localparam logic [V_W-1:0] LIM_RST [N_LIM] = '{
    V_W'(HARD_LO_RST), V_W'(CTL_LO_RST), V_W'(CTL_HI_RST), V_W'(HARD_HI_RST)
  };

  logic [V_W-1:0]    lim_w [N_LIM];
  logic [HOLD_W-1:0] hold_q;
  side_e             side;
  logic              hard, enter, accept;
  logic [REC_W-1:0]  rec_in, rec_out;

  // limit registers, address = index
  for (genvar g = 0; g < int'(N_LIM); g++) begin : g_lim
    logic [V_W-1:0] lim_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  lim_q <= LIM_RST[g];
      else if (cfg_we_i && cfg_addr_i == 3'(g))     lim_q <= cfg_wdata_i;
    end
    assign lim_w[g] = lim_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                hold_q <= HOLD_W'(HOLD_RST);
    else if (cfg_we_i && cfg_addr_i == HOLD_AD) hold_q <= cfg_wdata_i[HOLD_W-1:0];
  end

  vdg_classify #(.V_W(V_W)) u_cls (
    .v_i      (vsample_i),
    .hard_lo_i(lim_w[0]),
    .ctl_lo_i (lim_w[1]),
    .ctl_hi_i (lim_w[2]),
    .hard_hi_i(lim_w[3]),
    .side_o   (side),
    .hard_o   (hard)
  );

  vdg_actuator #(.HOLD_W(HOLD_W)) u_act (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .side_i    (side),
    .hold_i    (hold_q),
    .throttle_o(throttle_o),
    .phantom_o (phantom_o),
    .enter_o   (enter)
  );

  assign rec_in = {kind_code(hard, side == SIDE_HI), pc_i};

  vdg_evt_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (enter),
    .data_i  (rec_in),
    .accept_o(accept),
    .valid_o (evt_valid_o),
    .ready_i (evt_ready_i),
    .data_o  (rec_out)
  );

  assign evt_type_o = rec_out[REC_W-1 -: KIND_W];
  assign evt_pc_o   = rec_out[PC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_cnt_o <= '0;
      overflow_o  <= 1'b0;
    end else if (enter) begin
      if (total_cnt_o != '1) total_cnt_o <= total_cnt_o + CNT_W'(1);
      if (!accept)           overflow_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/vdg_checks.sv
module vdg_checks #(
  parameter int unsigned V_W   = 8,
  parameter int unsigned PC_W  = 32,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [V_W-1:0]   vsample_i,
  input logic [V_W-1:0]   ctl_lo_i,
  input logic [V_W-1:0]   ctl_hi_i,
  input logic             throttle_o,
  input logic             phantom_o,
  input logic             evt_valid_o,
  input logic             evt_ready_i,
  input logic [1:0]       evt_type_o,
  input logic [PC_W-1:0]  evt_pc_o,
  input logic [CNT_W-1:0] total_cnt_o,
  input logic             overflow_o
);
  p_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(throttle_o && phantom_o));

  p_throttle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsample_i < ctl_lo_i) |=> throttle_o);

  p_phantom_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsample_i > ctl_hi_i && vsample_i >= ctl_lo_i) |=> phantom_o);

  p_head_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !evt_ready_i) |=>
      (evt_valid_o && $stable(evt_pc_o) && $stable(evt_type_o)));

  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  p_cnt_sat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&total_cnt_o) |=> (&total_cnt_o));

  p_cnt_mono_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (total_cnt_o >= $past(total_cnt_o)));
endmodule

bind vdroop_guard vdg_checks #(.V_W(V_W), .PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vsample_i  (vsample_i),
  .ctl_lo_i   (lim_w[1]),
  .ctl_hi_i   (lim_w[2]),
  .throttle_o (throttle_o),
  .phantom_o  (phantom_o),
  .evt_valid_o(evt_valid_o),
  .evt_ready_i(evt_ready_i),
  .evt_type_o (evt_type_o),
  .evt_pc_o   (evt_pc_o),
  .total_cnt_o(total_cnt_o),
  .overflow_o (overflow_o)
);

// File: tb/sim_vdroop_guard.sv
module sim_vdroop_guard;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;
  localparam int DEPTH      = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [7:0]       vsample = 8'd100;
  logic [31:0]      pc = '0;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_addr = '0;
  logic [7:0]       cfg_wdata = '0;
  logic             throttle, phantom, evt_valid, evt_ready = 1'b0, overflow;
  logic [1:0]       evt_type;
  logic [31:0]      evt_pc;
  logic [CNT_W-1:0] total_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  vdroop_guard #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .vsample_i(vsample), .pc_i(pc),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .throttle_o(throttle), .phantom_o(phantom), .evt_valid_o(evt_valid),
    .evt_ready_i(evt_ready), .evt_type_o(evt_type), .evt_pc_o(evt_pc),
    .total_cnt_o(total_cnt), .overflow_o(overflow)
  );

  int errors = 0;
  int checks = 0;
  int pc_ctr = 0;

  // reference state
  int          m_lim [4] = '{50, 70, 130, 150};
  int          m_hold = 8;
  int          m_prev = 0;
  int          m_thr = 0, m_ph = 0, m_hc = 0;
  int          m_tot = 0, m_ovf = 0;
  int          q_n = 0;
  int          q_kind [DEPTH];
  logic [31:0] q_pc [DEPTH];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // one sample; drives after a falling edge, checks at the next falling edge
  task automatic cyc(input int v, input logic rdy, input logic we = 1'b0,
                     input int ad = 0, input int wd = 0);
    int s, hard, pop, ev;
    logic [31:0] cur_pc;
    cur_pc    = 32'h0040_0000 + 32'(pc_ctr) * 4;
    pc_ctr++;
    vsample   = 8'(v);
    pc        = cur_pc;
    evt_ready = rdy;
    cfg_we    = we;
    cfg_addr  = 3'(ad);
    cfg_wdata = 8'(wd);
    // R2 classification, R4 low priority
    if (v < m_lim[1])      begin s = 1; hard = (v < m_lim[0]) ? 1 : 0; end
    else if (v > m_lim[2]) begin s = 2; hard = (v > m_lim[3]) ? 1 : 0; end
    else                   begin s = 0; hard = 0; end
    pop = (q_n > 0 && rdy) ? 1 : 0;
    ev  = (s != 0 && s != m_prev) ? 1 : 0;
    if (pop == 1) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        q_kind[i] = q_kind[i+1];
        q_pc[i]   = q_pc[i+1];
      end
      q_n--;
    end
    if (ev == 1) begin
      m_tot = (m_tot == CNT_MAX) ? CNT_MAX : m_tot + 1;
      if (q_n < DEPTH) begin
        q_kind[q_n] = hard * 2 + ((s == 2) ? 1 : 0);
        q_pc[q_n]   = cur_pc;
        q_n++;
      end else m_ovf = 1;
    end
    if (s == 1)      begin m_thr = 1; m_ph = 0; m_hc = 0; end
    else if (s == 2) begin m_thr = 0; m_ph = 1; m_hc = 0; end
    else if (m_thr == 1 || m_ph == 1) begin
      if (m_hc + 1 >= m_hold) begin m_thr = 0; m_ph = 0; m_hc = 0; end
      else m_hc++;
    end
    m_prev = s;
    if (we) begin
      if (ad < 4)       m_lim[ad] = wd;
      else if (ad == 4) m_hold = wd % 16;
    end
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R3 R5 throttle", throttle, m_thr);
    chk("R4 R5 phantom", phantom, m_ph);
    chk("R8 valid", evt_valid, (q_n > 0) ? 1 : 0);
    if (q_n > 0) begin
      chk("R6 R7 kind", evt_type, q_kind[0]);
      chk("R6 R8 pc", evt_pc, q_pc[0]);
    end
    chk("R10 total", total_cnt, m_tot);
    chk("R9 overflow", overflow, m_ovf);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int kinds [4] = '{60, 140, 40, 160};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 throttle", throttle, 0);
    chk("R1 phantom", phantom, 0);
    chk("R1 valid", evt_valid, 0);
    chk("R1 total", total_cnt, 0);
    chk("R1 overflow", overflow, 0);
    rst_ni = 1'b1;
    cyc(100, 0);

    // fill queue with every kind, ready low (R6, R8)
    for (int i = 0; i < DEPTH; i++) begin
      cyc(kinds[i % 4], 0);
      cyc(100, 0);
    end
    // R9 push and pop in one cycle while full: accepted, no overflow
    cyc(45, 1);
    chk("R9 no overflow on push+pop", overflow, 0);
    cyc(100, 0);
    cyc(155, 0);
    chk("R9 overflow after drop", overflow, 1);
    // saturate the total counter (R10)
    for (int i = 0; i < 8; i++) begin
      cyc(kinds[i % 4], 0);
      cyc(100, 0);
    end
    chk("R10 saturated", total_cnt, CNT_MAX);
    // drain, order checked each cycle (R8)
    for (int i = 0; i < DEPTH + 2; i++) cyc(100, 1);
    chk("R8 drained", evt_valid, 0);

    // R7 staying outside makes one record, direct side swap makes another
    for (int i = 0; i < 6; i++) cyc(60, 0);
    chk("R7 one record", evt_valid, 1);
    cyc(140, 0);
    cyc(140, 0);
    for (int i = 0; i < 4; i++) cyc(100, 1);

    // R5 default hold of 8, restarted by an outside sample
    cyc(60, 1);
    for (int i = 0; i < 5; i++) cyc(100, 1);
    cyc(68, 1);
    for (int i = 0; i < 7; i++) cyc(100, 1);
    chk("R5 still held", throttle, 1);
    cyc(100, 1);
    chk("R5 released", throttle, 0);

    // R11 shorter hold, then sweep every code with default limits (R2, R6)
    cyc(100, 1, 1'b1, 4, 2);
    for (int v = 0; v < 256; v++) begin
      cyc(100, 1);
      cyc(100, 1);
      cyc(100, 1);
      cyc(v, 1);
    end

    // R11 writes to addresses 5..7 have no effect
    cyc(100, 1, 1'b1, 5, 0);
    cyc(100, 1, 1'b1, 6, 200);
    cyc(100, 1, 1'b1, 7, 1);
    for (int v = 45; v < 160; v += 5) begin
      cyc(100, 1);
      cyc(100, 1);
      cyc(v, 1);
    end

    // R11 reprogram limits; R4 crossed limits give throttle priority
    cyc(100, 1, 1'b1, 0, 20);
    cyc(100, 1, 1'b1, 3, 200);
    cyc(100, 1, 1'b1, 1, 140);
    cyc(100, 1, 1'b1, 2, 120);
    for (int v = 90; v < 170; v += 10) begin
      cyc(v, 1);
      chk("R4 priority low", throttle, (v < 140) ? 1 : 0);
    end
    for (int i = 0; i < 4; i++) cyc(130, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule